// File: doc/BRIEF.md
# Per-Core Power-Domain Sequencer

This block is the external power controller for a single processor core. While the core is running it watches two inputs: a two-bit low-power target field and a flag that the core raises when it enters wait-for-interrupt. When the flag is high and the field requests a deep mode, the block takes the core off power in an ordered sequence. It first applies the RAM input clamps, holds the RAM chip enable inactive and asserts the core reset. One cycle later it switches the power off. In dormant mode only the logic domain goes down, and the cache RAM domain stays powered in retention. In shutdown mode both domains go down.

An external wake-up event starts the way back. The block turns both domains on and keeps the clamps and reset asserted until a power-good input is seen. After that it waits for a programmable number of settle cycles. It then releases the clamps while reset is still held, and finally it releases reset. A wake-up event that arrives while the power-down sequence is under way is remembered and acted on as soon as the off state is reached. A status output keeps the last deep mode that was entered, across the core reset, so that boot code can decide whether saved state has to be restored.

Top module: `core_pwr_seq`

## Requirements
- R1: After controller reset, both power enables are high, retention is off, the clamps and the chip-enable hold are off, core reset is released (core_rst_n=1) and resume_mode is 2'b00.
- R2: Encoding of tgt_mode: 2'b10 is dormant and 2'b11 is shutdown. With 2'b00 (run) or 2'b01 (standby), a WFI entry has no effect on any power, clamp or reset output.
- R3: A power-down begins only in a cycle where wfi_entry is high and tgt_mode[1] is 1. A deep-mode value on tgt_mode alone does nothing.
- R4: The first cycle of a power-down has clamp_en=1, ram_ce_hold=1 and core_rst_n=0 while both power enables are still high. Logic power is removed in the next cycle.
- R5: In the dormant off state, logic_pwr_en=0, ram_pwr_en=1 and ram_ret=1, with the clamps applied and reset held.
- R6: In the shutdown off state, logic_pwr_en=0, ram_pwr_en=0 and ram_ret=0, with the clamps applied and reset held.
- R7: The off state persists until wake_evt is seen.
- R8: A wake_evt in the first power-down cycle is latched. The off state then lasts exactly one cycle before power is restored.
- R9: On wake-up, both power enables go high and ram_ret goes low, while the clamps and reset stay asserted until pwr_good is high.
- R10: After pwr_good is seen, the clamps stay on for settle_cycles+1 further cycles. They are then released for one cycle with reset still held, and then core_rst_n goes high.
- R11: resume_mode shows the last deep mode entered (2'b10 or 2'b11) from the first power-down cycle onward. It keeps that value through standby requests and core reset until the next deep entry or a controller reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low controller reset |
| tgt_mode | input | 2 | Requested low-power mode of the core |
| wfi_entry | input | 1 | Core has entered wait-for-interrupt |
| wake_evt | input | 1 | External wake-up request |
| pwr_good | input | 1 | Restored supplies are stable |
| settle_cycles | input | CNT_W | Extra cycles to wait after power-good |
| logic_pwr_en | output | 1 | Logic domain power switch enable |
| ram_pwr_en | output | 1 | RAM domain power switch enable |
| ram_ret | output | 1 | RAM domain in retention |
| clamp_en | output | 1 | Clamp RAM inputs to a fixed level |
| ram_ce_hold | output | 1 | Force RAM chip enable inactive |
| core_rst_n | output | 1 | Active-low core reset |
| resume_mode | output | 2 | Last deep mode entered |

## Verification
The bench builds the block with CNT_W=4, so the settle counter is narrow and every value it can take is cheap to reach. A table walks all four tgt_mode codes, including standby between two deep entries, so it shows that resume_mode holds its value. The table runs each restore with settle_cycles=3, and a directed run uses 0 so that the shortest settle path is covered as well. Directed cases also cover a deep mode requested without WFI, a held pwr_good, and a wake-up that lands in the clamp cycle.

// File: rtl/core_pwr_seq.sv
module core_pwr_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       tgt_mode,
  input  logic             wfi_entry,
  input  logic             wake_evt,
  input  logic             pwr_good,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             logic_pwr_en,
  output logic             ram_pwr_en,
  output logic             ram_ret,
  output logic             clamp_en,
  output logic             ram_ce_hold,
  output logic             core_rst_n,
  output logic [1:0]       resume_mode
);

  typedef enum logic [2:0] {
    S_RUN, S_CLAMP, S_OFF, S_PWRUP, S_SETTLE, S_UNCLAMP
  } st_t;

  st_t              st;
  logic             tgt_sd;
  logic             pend;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_RUN;
      tgt_sd      <= 1'b0;
      pend        <= 1'b0;
      cnt         <= '0;
      resume_mode <= 2'b00;
    end else begin
      case (st)
        S_RUN:
          if (wfi_entry && tgt_mode[1]) begin
            tgt_sd      <= tgt_mode[0];
            resume_mode <= tgt_mode;
            st          <= S_CLAMP;
          end
        S_CLAMP: begin
          if (wake_evt) pend <= 1'b1;
          st <= S_OFF;
        end
        S_OFF:
          if (wake_evt || pend) begin
            pend <= 1'b0;
            st   <= S_PWRUP;
          end
        S_PWRUP:
          if (pwr_good) begin
            cnt <= settle_cycles;
            st  <= S_SETTLE;
          end
        S_SETTLE:
          if (cnt == '0) st <= S_UNCLAMP;
          else cnt <= cnt - 1'b1;
        S_UNCLAMP: st <= S_RUN;
        default:   st <= S_RUN;
      endcase
    end
  end

  wire off = (st == S_OFF);

  assign logic_pwr_en = !off;
  assign ram_pwr_en   = !(off && tgt_sd);
  assign ram_ret      = off && !tgt_sd;
  assign clamp_en     = (st == S_CLAMP) || off || (st == S_PWRUP) || (st == S_SETTLE);
  assign ram_ce_hold  = clamp_en;
  assign core_rst_n   = (st == S_RUN);

  // R4
  clamp_before_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(logic_pwr_en) |-> $past(clamp_en) && $past(!core_rst_n));

  // R5
  ret_only_when_ram_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ret |-> ram_pwr_en && !logic_pwr_en && clamp_en);

  // R9
  unclamped_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_en |-> logic_pwr_en && ram_pwr_en);

  // R10
  reset_after_unclamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_n) |-> $past(!clamp_en) && logic_pwr_en);

  // R4
  clamp_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_en |-> !core_rst_n && ram_ce_hold);

endmodule

// File: tb/core_pwr_seq_bench.sv
module core_pwr_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] tgt_mode = 2'b00;
  logic wfi_entry = 1'b0, wake_evt = 1'b0, pwr_good = 1'b1;
  logic [3:0] settle_cycles = 4'd3;
  logic logic_pwr_en, ram_pwr_en, ram_ret, clamp_en, ram_ce_hold, core_rst_n;
  logic [1:0] resume_mode;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  core_pwr_seq #(.CNT_W(4)) u_core_pwr_seq (
    .clk(clk), .rst_n(rst_n), .tgt_mode(tgt_mode), .wfi_entry(wfi_entry),
    .wake_evt(wake_evt), .pwr_good(pwr_good), .settle_cycles(settle_cycles),
    .logic_pwr_en(logic_pwr_en), .ram_pwr_en(ram_pwr_en), .ram_ret(ram_ret),
    .clamp_en(clamp_en), .ram_ce_hold(ram_ce_hold), .core_rst_n(core_rst_n),
    .resume_mode(resume_mode));

  wire [5:0] outs = {logic_pwr_en, ram_pwr_en, ram_ret, clamp_en, ram_ce_hold, core_rst_n};
  localparam logic [5:0] O_RUN = 6'b110001, O_DORM = 6'b011110, O_SHUT = 6'b000110,
                         O_CLMP = 6'b110110, O_UNCL = 6'b110000;

  // {tgt_mode, expected outputs two cycles after WFI, expected resume_mode}
  localparam logic [9:0] VEC [4] = '{
    {2'b00, O_RUN,  2'b00},
    {2'b10, O_DORM, 2'b10},
    {2'b01, O_RUN,  2'b10},
    {2'b11, O_SHUT, 2'b11}
  };

  task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restore(input logic [3:0] settle);
    settle_cycles = settle;
    wake_evt = 1'b1; pwr_good = 1'b0;
    tick();
    wake_evt = 1'b0;
    chk("R9 powered, clamped", outs, O_CLMP);
    tick();
    chk("R9 waits pwr_good", outs, O_CLMP);
    pwr_good = 1'b1;
    for (int k = 0; k <= int'(settle); k++) begin
      tick();
      chk("R10 settle clamp", outs, O_CLMP);
    end
    tick();
    chk("R10 unclamp reset held", outs, O_UNCL);
    tick();
    chk("R10 reset released", outs, O_RUN);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", outs, O_RUN);
    chk("R1 resume_mode", {4'b0, resume_mode}, 6'd0);

    tgt_mode = 2'b10;
    repeat (3) tick();
    chk("R3 no WFI no action", outs, O_RUN);

    for (int i = 0; i < 4; i++) begin
      tgt_mode = VEC[i][9:8];
      wfi_entry = 1'b1;
      tick();
      wfi_entry = 1'b0;
      if (VEC[i][9]) chk("R4 clamp cycle", outs, O_CLMP);
      else chk("R2 standby/run ignored", outs, O_RUN);
      tick();
      chk(VEC[i][8] ? "R6 shutdown off" : (VEC[i][9] ? "R5 dormant off" : "R2 no power change"),
          outs, VEC[i][7:2]);
      chk("R11 resume_mode", {4'b0, resume_mode}, {4'b0, VEC[i][1:0]});
      if (VEC[i][9]) begin
        repeat (4) tick();
        chk("R7 stays off", outs, VEC[i][7:2]);
        restore(4'd3);
        chk("R11 kept over core reset", {4'b0, resume_mode}, {4'b0, VEC[i][1:0]});
      end
    end

    tgt_mode = 2'b10; wfi_entry = 1'b1;
    tick();
    wfi_entry = 1'b0; wake_evt = 1'b1;
    chk("R4 clamp cycle", outs, O_CLMP);
    tick();
    wake_evt = 1'b0;
    chk("R8 reaches off", outs, O_DORM);
    tick();
    chk("R8 latched wake", outs, O_CLMP);
    pwr_good = 1'b1; settle_cycles = 4'd0;
    tick();
    chk("R10 settle0 clamp", outs, O_CLMP);
    tick();
    chk("R10 settle0 unclamp", outs, O_UNCL);
    tick();
    chk("R10 settle0 run", outs, O_RUN);

    tgt_mode = 2'b11; wfi_entry = 1'b1;
    tick();
    wfi_entry = 1'b0;
    tick();
    chk("R6 shutdown off", outs, O_SHUT);
    restore(4'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog got=hung exp=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule